// File: doc/BRIEF.md
# Upper memory chip-select decoder

This block drives an active-low chip select for the top region of a 20-bit (1 MB) address space. The region always ends at address FFFFFh and its size is set by a small control register. Coming out of reset the size is 64 KB, so the region covers F0000h to FFFFFh. That default includes FFFF0h, the address of the first instruction fetch after reset.

A bus cycle is marked by `cyc_valid_i`, which stays high for every clock of the cycle. Two cycles are separated by at least one clock with `cyc_valid_i` low. On the first clock of a cycle the block captures whether `addr_i` falls in the region, using the size in force at that moment. It holds that decision until the cycle ends, even if the address bus or the size register changes in the meantime. The chip select is a register and only changes on a rising clock edge. It is forced inactive while the bus-hold acknowledge is high.

The size register takes a one-hot code. A write whose code is not one-hot is discarded, and the previous size stays in force.

Top module: `ucs_decoder`

## Requirements
- R1: `ucs_n_o` is a register. One clock after an edge that samples `cyc_valid_i` high, with the captured address inside the region and `hold_ack_i` low, it goes low. Otherwise it is high.
- R2: After reset the region is 64 KB, from F0000h to FFFFFh. F0000h and FFFFFh select; EFFFFh does not.
- R3: The first cycle after reset, at address FFFF0h, asserts the select.
- R4: A write with `cfg_we_i` high and exactly one bit k set in `cfg_size_i` sets the size to 2^(10+k) bytes, for k from 0 to 9. The region then starts at 100000h minus the size.
- R5: A write whose `cfg_size_i` has no bit set, or more than one bit set, is ignored. The previous size stays in force.
- R6: While `hold_ack_i` is high, `ucs_n_o` is high one clock later, whatever the address.
- R7: The in-region decision is taken on the first clock of a bus cycle and held until the cycle ends. Later changes to `addr_i` or to the size during that cycle have no effect on it.
- R8: When `cyc_valid_i` is low, `ucs_n_o` is high one clock later.
- R9: While `rst_n` is low, `ucs_n_o` is high.
- R10: The size limits decode exactly. At 512 KB (k=9), 80000h selects and 7FFFFh does not. At 1 KB (k=0), FFC00h selects and FFBFFh does not.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr_i | input | 20 | Bus address, captured on the first clock of a cycle |
| cyc_valid_i | input | 1 | High for every clock of a bus cycle |
| hold_ack_i | input | 1 | Bus-hold acknowledge; forces the select inactive |
| cfg_we_i | input | 1 | Size register write enable |
| cfg_size_i | input | 10 | One-hot size code; bit k selects 2^(10+k) bytes |
| ucs_n_o | output | 1 | Registered chip select, active low |

## Verification
The bench builds the block with its default parameters: a 20-bit address, ten size codes from 1 KB to 512 KB, and a 64 KB reset size. With these values both size limits can be reached, and the reset-time fetch address can be checked against the default region. The random phase draws addresses close to each region start, so that hits and misses at the boundary are both frequent. It also toggles bus hold and the address inside a cycle, and mixes legal writes with writes that have no bit set or several bits set.

// File: rtl/ucs_pkg.sv
package ucs_pkg;
  localparam int UCS_ADDR_W  = 20;
  localparam int UCS_MIN_LOG = 10;
  localparam int UCS_NSIZE   = 10;
  localparam int UCS_DEF_IDX = 6;

  // Address bit b must be one for a hit when the region size log2 is <= b.
  function automatic int need_limit(int bitpos, int min_log);
    return bitpos - min_log;
  endfunction
endpackage

// File: rtl/ucs_size_reg.sv
module ucs_size_reg #(
  parameter int NSIZE   = ucs_pkg::UCS_NSIZE,
  parameter int DEF_IDX = ucs_pkg::UCS_DEF_IDX
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             we_i,
  input  logic [NSIZE-1:0] wdata_i,
  output logic [NSIZE-1:0] size_oh_o,
  output logic             wr_ok_o
);
  localparam logic [NSIZE-1:0] DEF_OH = NSIZE'(1) << DEF_IDX;

  function automatic logic code_legal(logic [NSIZE-1:0] c);
    return $onehot(c);
  endfunction

  assign wr_ok_o = we_i && code_legal(wdata_i);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       size_oh_o <= DEF_OH;
    else if (wr_ok_o) size_oh_o <= wdata_i;
  end
endmodule

// File: rtl/ucs_region_match.sv
module ucs_region_match #(
  parameter int ADDR_W  = ucs_pkg::UCS_ADDR_W,
  parameter int NSIZE   = ucs_pkg::UCS_NSIZE,
  parameter int MIN_LOG = ucs_pkg::UCS_MIN_LOG
) (
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [NSIZE-1:0]  size_oh_i,
  output logic              hit_o
);
  logic [ADDR_W-1:0] need_one;

  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    localparam int LIM = ucs_pkg::need_limit(b, MIN_LOG);
    if (LIM < 0) begin : g_free
      assign need_one[b] = 1'b0;
    end else if (LIM >= NSIZE - 1) begin : g_all
      assign need_one[b] = |size_oh_i;
    end else begin : g_part
      assign need_one[b] = |size_oh_i[LIM:0];
    end
  end

  assign hit_o = &(addr_i | ~need_one);
endmodule

// File: rtl/ucs_cs_gen.sv
module ucs_cs_gen (
  input  logic clk,
  input  logic rst_n,
  input  logic cyc_valid_i,
  input  logic hold_i,
  input  logic hit_now_i,
  output logic cyc_start_o,
  output logic cyc_cont_o,
  output logic cs_n_o
);
  logic valid_d;
  logic hit_q;
  logic hit_sel;

  assign cyc_start_o = cyc_valid_i && !valid_d;
  assign cyc_cont_o  = cyc_valid_i && valid_d;
  assign hit_sel     = cyc_start_o ? hit_now_i : hit_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_d <= 1'b0;
      hit_q   <= 1'b0;
      cs_n_o  <= 1'b1;
    end else begin
      valid_d <= cyc_valid_i;
      if (cyc_start_o) hit_q <= hit_now_i;
      cs_n_o <= !(cyc_valid_i && hit_sel && !hold_i);
    end
  end
endmodule

// File: rtl/ucs_decoder.sv
module ucs_decoder #(
  parameter int ADDR_W  = ucs_pkg::UCS_ADDR_W,
  parameter int MIN_LOG = ucs_pkg::UCS_MIN_LOG,
  parameter int NSIZE   = ucs_pkg::UCS_NSIZE,
  parameter int DEF_IDX = ucs_pkg::UCS_DEF_IDX
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              cyc_valid_i,
  input  logic              hold_ack_i,
  input  logic              cfg_we_i,
  input  logic [NSIZE-1:0]  cfg_size_i,
  output logic              ucs_n_o
);
  logic [NSIZE-1:0] size_oh;
  logic             wr_ok;
  logic             hit_now;
  logic             cyc_start;
  logic             cyc_cont;

  ucs_size_reg #(.NSIZE(NSIZE), .DEF_IDX(DEF_IDX)) u_size (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_size_i),
    .size_oh_o(size_oh), .wr_ok_o(wr_ok)
  );

  ucs_region_match #(.ADDR_W(ADDR_W), .NSIZE(NSIZE), .MIN_LOG(MIN_LOG)) u_match (
    .addr_i(addr_i), .size_oh_i(size_oh), .hit_o(hit_now)
  );

  ucs_cs_gen u_cs (
    .clk(clk), .rst_n(rst_n), .cyc_valid_i(cyc_valid_i), .hold_i(hold_ack_i),
    .hit_now_i(hit_now), .cyc_start_o(cyc_start), .cyc_cont_o(cyc_cont),
    .cs_n_o(ucs_n_o)
  );
endmodule

// File: rtl/ucs_decoder_chk.sv
module ucs_decoder_chk #(
  parameter int NSIZE = ucs_pkg::UCS_NSIZE
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cyc_valid_i,
  input logic             hold_ack_i,
  input logic             cfg_we_i,
  input logic [NSIZE-1:0] cfg_size_i,
  input logic [NSIZE-1:0] size_oh,
  input logic             cyc_cont,
  input logic             ucs_n_o
);
  a_r6_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    hold_ack_i |=> ucs_n_o);

  a_r8_no_cycle_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_valid_i |=> ucs_n_o);

  a_r4_legal_write: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && $onehot(cfg_size_i)) |=> (size_oh == $past(cfg_size_i)));

  a_r5_illegal_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_we_i && !$onehot(cfg_size_i)) |=> $stable(size_oh));

  a_r5_size_onehot: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot(size_oh));

  a_r7_held_decision: assert property (@(posedge clk) disable iff (!rst_n)
    (cyc_cont && !hold_ack_i && !$past(hold_ack_i)) |=> $stable(ucs_n_o));
endmodule

bind ucs_decoder ucs_decoder_chk #(.NSIZE(NSIZE)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_valid_i(cyc_valid_i), .hold_ack_i(hold_ack_i),
  .cfg_we_i(cfg_we_i), .cfg_size_i(cfg_size_i), .size_oh(size_oh),
  .cyc_cont(cyc_cont), .ucs_n_o(ucs_n_o)
);

// File: tb/ucs_decoder_tb.sv
`timescale 1ns/1ps
module ucs_decoder_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [19:0] addr_i = '0;
  logic        cyc_valid_i = 1'b0;
  logic        hold_ack_i = 1'b0;
  logic        cfg_we_i = 1'b0;
  logic [9:0]  cfg_size_i = '0;
  logic        ucs_n_o;

  int n_chk = 0;
  int n_fail = 0;

  int          m_log = 16;
  bit          m_prev = 1'b0;
  logic [19:0] m_lat_addr = '0;
  int          m_lat_log = 16;

  always #2 clk = ~clk;

  ucs_decoder u_dut (
    .clk(clk), .rst_n(rst_n), .addr_i(addr_i), .cyc_valid_i(cyc_valid_i),
    .hold_ack_i(hold_ack_i), .cfg_we_i(cfg_we_i), .cfg_size_i(cfg_size_i),
    .ucs_n_o(ucs_n_o)
  );

  function automatic bit in_region(logic [19:0] a, int lg);
    return int'(a) >= (32'h100000 - (1 << lg));
  endfunction

  task automatic check(logic act, logic exp, string req);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: ucs_n_o actual %b expected %b", req, act, exp);
    end
  endtask

  task automatic step(bit v, logic [19:0] a, bit h, bit we, logic [9:0] wd, string req);
    bit   start;
    logic exp_n;
    start = v && !m_prev;
    if (start) begin
      m_lat_addr = a;
      m_lat_log  = m_log;
    end
    exp_n = !(v && in_region(m_lat_addr, m_lat_log) && !h);
    if (we && $countones(wd) == 1)
      for (int k = 0; k < 10; k++) if (wd[k]) m_log = 10 + k;
    m_prev = v;
    cyc_valid_i = v; addr_i = a; hold_ack_i = h; cfg_we_i = we; cfg_size_i = wd;
    @(posedge clk);
    @(negedge clk);
    check(ucs_n_o, exp_n, req);
  endtask

  task automatic wr(logic [9:0] wd, string req);
    step(1'b0, 20'h0, 1'b0, 1'b1, wd, req);
  endtask

  task automatic bus(logic [19:0] a, string req);
    step(1'b1, a, 1'b0, 1'b0, '0, req);
    step(1'b0, a, 1'b0, 1'b0, '0, "R8");
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    check(ucs_n_o, 1'b1, "R9 reset");
    rst_n = 1'b1;
    // R3: reset fetch address selects in the first cycle
    bus(20'hFFFF0, "R3");
    // R2: default 64 KB region
    bus(20'hF0000, "R2 low edge");
    bus(20'hEFFFF, "R2 below");
    bus(20'hFFFFF, "R2 top");
    // R4 / R10: largest and smallest sizes
    wr(10'h200, "R4");
    bus(20'h80000, "R10 512K hit");
    bus(20'h7FFFF, "R10 512K miss");
    wr(10'h001, "R4");
    bus(20'hFFC00, "R10 1K hit");
    bus(20'hFFBFF, "R10 1K miss");
    // R5: illegal codes leave 1 KB in force
    wr(10'h000, "R5");
    wr(10'h003, "R5");
    bus(20'hFFBFF, "R5 still 1K miss");
    bus(20'hFFC00, "R5 still 1K hit");
    wr(10'h040, "R4");
    // R6: hold forces high, release mid-cycle reasserts
    step(1'b1, 20'hFFFF0, 1'b1, 1'b0, '0, "R6 hold");
    step(1'b1, 20'hFFFF0, 1'b0, 1'b0, '0, "R6 release");
    step(1'b0, 20'h0, 1'b0, 1'b0, '0, "R8");
    // R7: address and size change inside a cycle are ignored
    step(1'b1, 20'hFFFF0, 1'b0, 1'b0, '0, "R7 start");
    step(1'b1, 20'h00000, 1'b0, 1'b1, 10'h001, "R7 addr moved");
    step(1'b1, 20'h12345, 1'b0, 1'b0, '0, "R7 held");
    step(1'b0, 20'h0, 1'b0, 1'b0, '0, "R8");
    step(1'b1, 20'h00000, 1'b0, 1'b0, '0, "R7 miss start");
    step(1'b1, 20'hFFFFF, 1'b0, 1'b0, '0, "R7 miss held");
    step(1'b0, 20'h0, 1'b0, 1'b0, '0, "R8");
    // Random phase
    for (int i = 0; i < 400; i++) begin
      int len;
      logic [19:0] base;
      logic [9:0]  wd;
      if ($urandom_range(0, 3) == 0) begin
        case ($urandom_range(0, 2))
          0: wd = 10'(1) << $urandom_range(0, 9);
          1: wd = 10'h0;
          default: wd = 10'($urandom) | 10'h003;
        endcase
        wr(wd, "R4 R5 random write");
      end
      base = 20'(32'h100000 - (1 << ($urandom_range(10, 19))));
      len = $urandom_range(1, 4);
      for (int c = 0; c < len; c++) begin
        logic [19:0] a;
        a = (c == 0 || $urandom_range(0, 1) == 0)
            ? 20'(base + 20'($urandom_range(0, 8)) - 20'd4) : 20'($urandom);
        step(1'b1, a, $urandom_range(0, 5) == 0, 1'b0, '0, "R1 R6 R7 random");
      end
      step(1'b0, 20'($urandom), $urandom_range(0, 1) == 1, 1'b0, '0, "R8 random");
    end
    finish_run();
  end
endmodule